// File: doc/BRIEF.md
# Interrupt Context Bank Selector

This block selects which of several complete register banks a processor core is using. All banks share one register RAM. The block drives the upper address bits of that RAM with the active context number. A bank holds a full register set, including the program counter, the link register and the status word. Taking an interrupt therefore needs no register save and no restore. The block only moves the RAM to a different bank. The switch happens at the next instruction boundary that the core signals.

Software fills a small table that assigns a context number to each interrupt line, and it sets a global enable. When the core signals an instruction boundary, the block looks for an eligible pending line. It pushes the current context onto a small hardware stack, selects the mapped context, and pulses an acknowledge that carries the line number. A return-from-context strobe pops the stack and selects the interrupted context again.

A write window lets software reach every register of every bank after reset. The block turns a window write into a RAM write address made of a bank number and a register index. The bus is write-only and every write is accepted on the cycle it is presented. It has no ready signal and never applies back-pressure.

Top module: `ctx_bank_selector`

## Requirements
- R1: After reset, `ctx_sel` is 0 and `ack` is 0. Every table entry is 0 and the global enable is off, so no pending line is taken at a boundary until software sets the enable.
- R2: A bus write with `bus_addr[8]`=0 writes the control space. Offsets 0 to 3 set the context of interrupt lines 0 to 3 from `bus_wdata[3:0]`. Offset 4 sets the global enable from `bus_wdata[0]`. Clearing the enable stops interrupts from being taken.
- R3: A switch happens only on a cycle with `instr_boundary` or `ret_ctx` high. `ctx_sel` takes its new value at that clock edge and holds it in every other cycle.
- R4: When a line is taken, `ack` is high for exactly that one cycle after the edge. `ack_irq` gives the line number and `ctx_sel` already shows the mapped context.
- R5: When several eligible lines are pending at a boundary, the lowest-numbered one is taken.
- R6: A line whose mapped context equals `ctx_sel` is not eligible. It stays pending, and it can be taken after a return changes `ctx_sel`.
- R7: `ret_ctx` restores the context that was active before the most recent take. With no saved context it has no effect.
- R8: The block saves up to 4 previous contexts. While 4 are saved, a pending line is held and not taken. It is taken at a later boundary once a return has freed a slot.
- R9: A bus write with `bus_addr[8]`=1 is a window write. One cycle later `win_we` is 1 for one cycle, `win_addr` equals `bus_addr[7:0]` (bank in bits 7:4, register index in bits 3:0) and `win_data` equals `bus_wdata`.
- R10: When `ret_ctx` and `instr_boundary` are high in the same cycle, the return is performed and no interrupt is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 4 | Pending interrupt lines, level |
| instr_boundary | input | 1 | Core is at an instruction boundary |
| ret_ctx | input | 1 | Return-from-context instruction strobe |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 9 | Bus address; bit 8 selects the window |
| bus_wdata | input | 16 | Bus write data |
| ctx_sel | output | 4 | Active bank, upper register-RAM address bits |
| ack | output | 1 | One-cycle interrupt-taken pulse |
| ack_irq | output | 2 | Number of the line that was taken |
| win_we | output | 1 | Register-RAM write from the window |
| win_addr | output | 8 | Window write address {bank, register} |
| win_data | output | 16 | Window write data |

## Verification
All results are registered once. A boundary, a return or a window write presented before clock edge N shows up on `ctx_sel`, `ack`, `ack_irq` and the window outputs just after edge N, and disappears after edge N+1. Table and enable writes take effect one edge after the write, so they govern the boundary presented in the next cycle. The bench drives each stimulus on a falling edge and samples the outputs on the following falling edge, exactly one rising edge later. It clears the strobes at that same falling edge.

// File: rtl/ctx_sel_pkg.sv
package ctx_sel_pkg;
  // Bus address regions, decoded from the top address bit.
  typedef enum logic {
    RGN_CTRL = 1'b0,
    RGN_WIN  = 1'b1
  } bus_region_e;
endpackage

// File: rtl/ctx_irq_map.sv
module ctx_irq_map #(
  parameter int NUM_IRQ = 4,
  parameter int CTX_W   = 4,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [NUM_IRQ*CTX_W-1:0] map_flat,
  output logic                     irq_enable
);
  import ctx_sel_pkg::*;
  localparam int OFF_W = ADDR_W - 1;

  logic ctrl_we;
  assign ctrl_we = bus_we && (bus_region_e'(bus_addr[ADDR_W-1]) == RGN_CTRL);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_entry
    logic [CTX_W-1:0] entry_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry_q <= '0;
      else if (ctrl_we && bus_addr[OFF_W-1:0] == OFF_W'(i))
        entry_q <= bus_wdata[CTX_W-1:0];
    end
    assign map_flat[i*CTX_W +: CTX_W] = entry_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_enable <= 1'b0;
    else if (ctrl_we && bus_addr[OFF_W-1:0] == OFF_W'(NUM_IRQ))
      irq_enable <= bus_wdata[0];
  end
endmodule

// File: rtl/ctx_pick.sv
module ctx_pick #(
  parameter int NUM_IRQ = 4,
  parameter int CTX_W   = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_IRQ-1:0]       irq_in,
  input  logic [NUM_IRQ*CTX_W-1:0] map_flat,
  input  logic [CTX_W-1:0]         cur_ctx,
  input  logic                     enable,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx,
  output logic [CTX_W-1:0]         hit_ctx
);
  logic [NUM_IRQ-1:0] eligible;

  // A line mapped onto the active context is not re-entered.
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_elig
    assign eligible[i] = enable && irq_in[i] &&
                         (map_flat[i*CTX_W +: CTX_W] != cur_ctx);
  end

  // Scan downward so the lowest eligible line is the last one written.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    hit_ctx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
        hit_ctx = map_flat[i*CTX_W +: CTX_W];
      end
    end
  end
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack #(
  parameter int CTX_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [CTX_W-1:0] push_ctx,
  output logic [CTX_W-1:0] top_ctx,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CTX_W-1:0] slot_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_m1;

  assign cnt_m1  = cnt_q - 1'b1;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_ctx = slot_q[cnt_m1[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (push && !full) begin
      slot_q[cnt_q[PTR_W-1:0]] <= push_ctx;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop && !empty) begin
      cnt_q <= cnt_m1;
    end
  end
endmodule

// File: rtl/ctx_bank_selector.sv
module ctx_bank_selector #(
  parameter int NUM_IRQ     = 4,
  parameter int CTX_W       = 4,
  parameter int REG_W       = 4,
  parameter int DATA_W      = 16,
  parameter int STACK_DEPTH = 4,
  localparam int IDX_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int WIN_W      = CTX_W + REG_W,
  localparam int ADDR_W     = WIN_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               instr_boundary,
  input  logic               ret_ctx,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [CTX_W-1:0]   ctx_sel,
  output logic               ack,
  output logic [IDX_W-1:0]   ack_irq,
  output logic               win_we,
  output logic [WIN_W-1:0]   win_addr,
  output logic [DATA_W-1:0]  win_data
);
  import ctx_sel_pkg::*;

  logic [NUM_IRQ*CTX_W-1:0] map_flat;
  logic                     irq_enable;
  logic                     hit;
  logic [IDX_W-1:0]         hit_idx;
  logic [CTX_W-1:0]         hit_ctx;
  logic [CTX_W-1:0]         saved_ctx;
  logic                     stk_empty, stk_full;
  logic                     do_pop, do_take;

  ctx_irq_map #(.NUM_IRQ(NUM_IRQ), .CTX_W(CTX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .map_flat(map_flat), .irq_enable(irq_enable)
  );

  ctx_pick #(.NUM_IRQ(NUM_IRQ), .CTX_W(CTX_W), .IDX_W(IDX_W)) u_pick (
    .irq_in(irq_in), .map_flat(map_flat), .cur_ctx(ctx_sel), .enable(irq_enable),
    .hit(hit), .hit_idx(hit_idx), .hit_ctx(hit_ctx)
  );

  // A return has priority; an interrupt waits while the stack is full.
  assign do_pop  = ret_ctx && !stk_empty;
  assign do_take = instr_boundary && !ret_ctx && hit && !stk_full;

  ctx_stack #(.CTX_W(CTX_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(do_take), .pop(do_pop),
    .push_ctx(ctx_sel), .top_ctx(saved_ctx), .empty(stk_empty), .full(stk_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_sel <= '0;
      ack     <= 1'b0;
      ack_irq <= '0;
    end else begin
      ack <= do_take;
      if (do_pop)
        ctx_sel <= saved_ctx;
      else if (do_take) begin
        ctx_sel <= hit_ctx;
        ack_irq <= hit_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_we   <= 1'b0;
      win_addr <= '0;
      win_data <= '0;
    end else begin
      win_we <= bus_we && (bus_region_e'(bus_addr[ADDR_W-1]) == RGN_WIN);
      if (bus_we) begin
        win_addr <= bus_addr[WIN_W-1:0];
        win_data <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/ctx_bank_selector_chk.sv
module ctx_bank_selector_chk #(
  parameter int NUM_IRQ = 4,
  parameter int CTX_W   = 4,
  parameter int IDX_W   = 2,
  parameter int WIN_W   = 8,
  parameter int ADDR_W  = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_in,
  input logic               instr_boundary,
  input logic               ret_ctx,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [CTX_W-1:0]   ctx_sel,
  input logic               ack,
  input logic [IDX_W-1:0]   ack_irq,
  input logic               win_we,
  input logic [WIN_W-1:0]   win_addr
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_boundary && !ret_ctx) |=> $stable(ctx_sel));

  p_ack_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ((($past(irq_in) >> ack_irq) & NUM_IRQ'(1)) != '0));

  p_ack_moves_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ctx_sel != $past(ctx_sel)));

  p_ret_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ctx |=> !ack);

  p_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[ADDR_W-1]) |=> (win_we && win_addr == $past(bus_addr[WIN_W-1:0])));

  p_nowin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr[ADDR_W-1]) |=> !win_we);
endmodule

bind ctx_bank_selector ctx_bank_selector_chk #(
  .NUM_IRQ(NUM_IRQ), .CTX_W(CTX_W), .IDX_W(IDX_W), .WIN_W(WIN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .instr_boundary(instr_boundary),
  .ret_ctx(ret_ctx), .bus_we(bus_we), .bus_addr(bus_addr), .ctx_sel(ctx_sel),
  .ack(ack), .ack_irq(ack_irq), .win_we(win_we), .win_addr(win_addr)
);

// File: tb/ctx_bank_selector_bench.sv
module ctx_bank_selector_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_IDLE = 3'd0, OP_WR = 3'd1, OP_STEP = 3'd2,
                         OP_RET = 3'd3, OP_BOTH = 3'd4;
  localparam int NV = 25;
  // {op, addr[9], data[16], irq[4], exp_ctx[4], exp_ack, exp_idx[2]}
  localparam logic [38:0] VEC [NV] = '{
    {OP_WR,   9'd0, 16'd3, 4'b0000, 4'd0, 1'b0, 2'd0},  // R2 irq0 -> 3
    {OP_WR,   9'd1, 16'd5, 4'b0000, 4'd0, 1'b0, 2'd0},  // R2 irq1 -> 5
    {OP_WR,   9'd2, 16'd0, 4'b0000, 4'd0, 1'b0, 2'd0},  // R2 irq2 -> 0
    {OP_WR,   9'd3, 16'd7, 4'b0000, 4'd0, 1'b0, 2'd0},  // R2 irq3 -> 7
    {OP_STEP, 9'd0, 16'd0, 4'b0001, 4'd0, 1'b0, 2'd0},  // R1 disabled
    {OP_WR,   9'd4, 16'd1, 4'b0000, 4'd0, 1'b0, 2'd0},  // R2 enable
    {OP_IDLE, 9'd0, 16'd0, 4'b0001, 4'd0, 1'b0, 2'd0},  // R3 no boundary
    {OP_STEP, 9'd0, 16'd0, 4'b0100, 4'd0, 1'b0, 2'd0},  // R6 self-mapped
    {OP_STEP, 9'd0, 16'd0, 4'b0110, 4'd5, 1'b1, 2'd1},  // R5 R6 skip self
    {OP_STEP, 9'd0, 16'd0, 4'b1011, 4'd3, 1'b1, 2'd0},  // R5 lowest wins
    {OP_STEP, 9'd0, 16'd0, 4'b0001, 4'd3, 1'b0, 2'd0},  // R6 not re-entered
    {OP_RET,  9'd0, 16'd0, 4'b0000, 4'd5, 1'b0, 2'd0},  // R7
    {OP_RET,  9'd0, 16'd0, 4'b0000, 4'd0, 1'b0, 2'd0},  // R7
    {OP_RET,  9'd0, 16'd0, 4'b0000, 4'd0, 1'b0, 2'd0},  // R7 empty
    {OP_STEP, 9'd0, 16'd0, 4'b1000, 4'd7, 1'b1, 2'd3},  // R4 depth1
    {OP_STEP, 9'd0, 16'd0, 4'b0001, 4'd3, 1'b1, 2'd0},  // R4 depth2
    {OP_STEP, 9'd0, 16'd0, 4'b0010, 4'd5, 1'b1, 2'd1},  // R4 depth3
    {OP_STEP, 9'd0, 16'd0, 4'b1000, 4'd7, 1'b1, 2'd3},  // R8 depth4
    {OP_STEP, 9'd0, 16'd0, 4'b0001, 4'd7, 1'b0, 2'd0},  // R8 full, held
    {OP_RET,  9'd0, 16'd0, 4'b0000, 4'd5, 1'b0, 2'd0},  // R7
    {OP_STEP, 9'd0, 16'd0, 4'b0001, 4'd3, 1'b1, 2'd0},  // R8 taken after pop
    {OP_BOTH, 9'd0, 16'd0, 4'b0010, 4'd5, 1'b0, 2'd0},  // R10 return wins
    {OP_RET,  9'd0, 16'd0, 4'b0000, 4'd3, 1'b0, 2'd0},  // R7
    {OP_RET,  9'd0, 16'd0, 4'b0000, 4'd7, 1'b0, 2'd0},  // R7
    {OP_RET,  9'd0, 16'd0, 4'b0000, 4'd0, 1'b0, 2'd0}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  irq_in;
  logic        instr_boundary, ret_ctx, bus_we;
  logic [8:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [3:0]  ctx_sel;
  logic        ack;
  logic [1:0]  ack_irq;
  logic        win_we;
  logic [7:0]  win_addr;
  logic [15:0] win_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ctx_bank_selector u_ctx_bank_selector (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .instr_boundary(instr_boundary),
    .ret_ctx(ret_ctx), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ctx_sel(ctx_sel), .ack(ack), .ack_irq(ack_irq), .win_we(win_we),
    .win_addr(win_addr), .win_data(win_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    irq_in = '0; instr_boundary = 1'b0; ret_ctx = 1'b0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  // Called at a falling edge: drive, pass one rising edge, return at the next falling edge.
  task automatic cycle(input logic [2:0] op, input logic [8:0] a,
                       input logic [15:0] d, input logic [3:0] irq);
    irq_in         = irq;
    bus_we         = (op == OP_WR);
    bus_addr       = a;
    bus_wdata      = d;
    instr_boundary = (op == OP_STEP) || (op == OP_BOTH);
    ret_ctx        = (op == OP_RET)  || (op == OP_BOTH);
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_in();
    repeat (3) @(negedge clk);
    chk("R1 reset ctx_sel", 32'(ctx_sel), 32'd0);
    chk("R1 reset ack", 32'(ack), 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [38:0] e;
      e = VEC[v];
      cycle(e[38:36], e[35:27], e[26:11], e[10:7]);
      chk($sformatf("vec%0d ctx_sel (R3 R7)", v), 32'(ctx_sel), 32'(e[6:3]));
      chk($sformatf("vec%0d ack (R4)", v), 32'(ack), 32'(e[2]));
      if (e[2]) chk($sformatf("vec%0d ack_irq (R5)", v), 32'(ack_irq), 32'(e[1:0]));
    end

    // R9 window write
    cycle(OP_WR, 9'h169, 16'hBEEF, 4'b0000);
    chk("R9 win_we", 32'(win_we), 32'd1);
    chk("R9 win_addr", 32'(win_addr), 32'h69);
    chk("R9 win_data", 32'(win_data), 32'hBEEF);
    cycle(OP_IDLE, 9'd0, 16'd0, 4'b0000);
    chk("R9 win_we drops", 32'(win_we), 32'd0);
    cycle(OP_WR, 9'd2, 16'd9, 4'b0000);
    chk("R9 ctrl write no window", 32'(win_we), 32'd0);

    // R2 disable blocks taking
    cycle(OP_WR, 9'd4, 16'd0, 4'b0000);
    cycle(OP_STEP, 9'd0, 16'd0, 4'b0001);
    chk("R2 disabled ctx_sel", 32'(ctx_sel), 32'd0);
    chk("R2 disabled ack", 32'(ack), 32'd0);

    // R1 reset mid-run clears context and table
    cycle(OP_WR, 9'd4, 16'd1, 4'b0000);
    cycle(OP_STEP, 9'd0, 16'd0, 4'b0010);
    chk("R4 pre-reset take", 32'(ctx_sel), 32'd5);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mid reset ctx_sel", 32'(ctx_sel), 32'd0);
    chk("R1 mid reset ack", 32'(ack), 32'd0);
    rst_n = 1'b1;
    cycle(OP_STEP, 9'd0, 16'd0, 4'b0010);
    chk("R1 enable cleared", 32'(ack), 32'd0);
    cycle(OP_WR, 9'd4, 16'd1, 4'b0000);
    cycle(OP_STEP, 9'd0, 16'd0, 4'b0011);
    chk("R1 table cleared ack", 32'(ack), 32'd0);
    chk("R1 table cleared ctx", 32'(ctx_sel), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule